// File: doc/BRIEF.md
# Bidirectional Peripheral Port with Strobe Latching

This block is one 8-bit peripheral port of a processor-bus interface adapter. It has a direction register that sets each pin as an input or an output, and an output register that drives the pins set as outputs. A read of the port returns either the current pin levels or a snapshot that was captured when a strobe line made its active transition. Pins are modelled as tri-state: the block drives an output value and a per-bit output enable, and receives the pad level on a separate input.

Software reaches four registers over a small synchronous bus: the port data, the direction, a control register and a strobe flag. The control register sets three things: whether latching is on, which strobe edge counts as active, and which of two read-back flavours the port uses. The "A" flavour always reads pins. The "B" flavour reads the output-register bit in place of the pin for every bit set as an output. The pin and strobe inputs pass through two-flop synchronizers before any logic uses them.

Top module: `pio_port`

## Requirements
- R1: Register address 1 holds the direction; a 1 in bit n sets `pin_oe_o[n]` high (output), a 0 sets it low (input). A read of address 1 returns the stored direction.
- R2: For each bit set as an output, `pin_o` equals the output register bit (1 drives high, 0 drives low); for an input bit `pin_o` is 0. A write to address 0 loads the output register.
- R3: An output register bit written while its pin is an input is stored. It leaves the pin undriven, and it appears on the pin once that bit becomes an output.
- R4: With latching off (control bit 0 = 0), a read of address 0 in flavour A returns the synchronized pin levels, two clocks behind `pin_i`.
- R5: In flavour B (control bit 2 = 1), a read of address 0 returns the output register bit for output bits and the synchronized pin for input bits.
- R6: An active strobe transition sets the flag. Control bit 1 = 1 makes a rising edge active and 0 makes a falling edge active. The flag shows on `flag_o` and as bit 0 of address 3. Writing 1 to bit 0 of address 3 clears it. When a set and a clear fall in the same cycle, the set wins.
- R7: In flavour A with latching on, a port read returns the snapshot taken at the last active edge that found the flag clear. The snapshot persists after the flag is cleared, until the next such edge, and is 0 before any edge.
- R8: In flavour B with latching on, a port read returns the captured mix of output register bits and input pins while the flag is set. Once the flag is cleared, it returns the live mix.
- R9: Active strobe edges that arrive while the flag is set leave the snapshot unchanged.
- R10: Reset, active low and asynchronous, clears direction, output, control and flag to 0. All pins become inputs and `pin_o` is 0.
- R11: A read of address 2 returns the three control bits in bits 2:0 and zeros above them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register select: 0 port, 1 direction, 2 control, 3 flag |
| wr_en_i | input | 1 | Write strobe for the selected register |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected register (combinational) |
| pin_i | input | 8 | Pad levels seen at the pins |
| pin_o | output | 8 | Value driven on the pins |
| pin_oe_o | output | 8 | Per-pin output enable |
| strobe_i | input | 1 | Strobe control line |
| flag_o | output | 1 | Strobe flag |

## Verification
The hardest case to reach from the ports is a flag clear that lands in the same clock as a new active edge. The edge only becomes visible after the synchronizer and the edge register. The bench moves the strobe on a falling clock edge, counts two rising edges, and then issues the clear write so that both take effect at the same edge. It then checks that the flag stays set and that a fresh snapshot was captured. A second difficult case is an edge that arrives while the flag is held. The bench changes the pins between two edges and confirms that the read still returns the first snapshot.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_PORT = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_DIR  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_FLAG = 2'd3;

  // bit 2: flavour B, bit 1: rising edge active, bit 0: latch enable
  typedef struct packed {
    logic port_b;
    logic rise;
    logic latch_en;
  } ctrl_t;
  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pio_regs.sv
module pio_regs
  import pio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [W-1:0]      port_rd_i,
  input  logic              flag_i,
  output logic [W-1:0]      dir_o,
  output logic [W-1:0]      out_o,
  output ctrl_t             ctrl_o,
  output logic              clr_o,
  output logic [W-1:0]      rdata_o
);
  logic wr_port, wr_dir, wr_ctrl;

  assign wr_port = wr_en_i && (addr_i == ADDR_PORT);
  assign wr_dir  = wr_en_i && (addr_i == ADDR_DIR);
  assign wr_ctrl = wr_en_i && (addr_i == ADDR_CTRL);
  assign clr_o   = wr_en_i && (addr_i == ADDR_FLAG) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o  <= '0;
      out_o  <= '0;
      ctrl_o <= '0;
    end else begin
      if (wr_dir)  dir_o  <= wdata_i;
      if (wr_port) out_o  <= wdata_i;
      if (wr_ctrl) ctrl_o <= ctrl_t'(wdata_i[CTRL_W-1:0]);
    end
  end

  always_comb begin
    unique case (addr_i)
      ADDR_PORT: rdata_o = port_rd_i;
      ADDR_DIR:  rdata_o = dir_o;
      ADDR_CTRL: rdata_o = W'(ctrl_o);
      default:   rdata_o = W'(flag_i);
    endcase
  end

  a_r11_ctrl_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl |=> (ctrl_o == $past(wdata_i[CTRL_W-1:0])));
endmodule

// File: rtl/pio_capture.sv
module pio_capture #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         strb_i,
  input  logic         rise_i,
  input  logic         clr_i,
  input  logic [W-1:0] view_i,
  output logic         flag_o,
  output logic [W-1:0] snap_o
);
  logic strb_q, act_edge;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strb_q <= 1'b0;
    else         strb_q <= strb_i;
  end

  assign act_edge = rise_i ? (strb_i & ~strb_q) : (~strb_i & strb_q);

  // set beats clear; snapshot only refreshed when the flag was clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o <= 1'b0;
      snap_o <= '0;
    end else begin
      if (act_edge)   flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
      if (act_edge && !flag_o) snap_o <= view_i;
    end
  end

  a_r6_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_edge |=> flag_o);
  a_r6_flag_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !act_edge) |=> !flag_o);
  a_r9_snap_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o |=> $stable(snap_o));
endmodule

// File: rtl/pio_port.sv
module pio_port
  import pio_pkg::*;
#(
  parameter int W         = 8,
  parameter int SYNC_STGS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  input  logic [W-1:0]      pin_i,
  output logic [W-1:0]      pin_o,
  output logic [W-1:0]      pin_oe_o,
  input  logic              strobe_i,
  output logic              flag_o
);
  logic [W-1:0] pins_s, dir, outr, view, snap, port_rd;
  logic         strb_s, clr;
  ctrl_t        ctrl;

  pio_sync #(.W(W), .STAGES(SYNC_STGS)) u_pin_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(pins_s));

  pio_sync #(.W(1), .STAGES(SYNC_STGS)) u_strb_sync (
    .clk_i, .rst_ni, .d_i(strobe_i), .q_o(strb_s));

  pio_regs #(.W(W)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wr_en_i, .wdata_i,
    .port_rd_i(port_rd), .flag_i(flag_o),
    .dir_o(dir), .out_o(outr), .ctrl_o(ctrl), .clr_o(clr), .rdata_o);

  // flavour B replaces output bits with the output register
  assign view = ctrl.port_b ? ((outr & dir) | (pins_s & ~dir)) : pins_s;

  pio_capture #(.W(W)) u_cap (
    .clk_i, .rst_ni, .strb_i(strb_s), .rise_i(ctrl.rise), .clr_i(clr),
    .view_i(view), .flag_o, .snap_o(snap));

  always_comb begin
    if (!ctrl.latch_en)   port_rd = view;
    else if (ctrl.port_b) port_rd = flag_o ? snap : view;
    else                  port_rd = snap;
  end

  assign pin_oe_o = dir;
  assign pin_o    = outr & dir;

  always_comb begin
    if (!rst_ni) a_r10_reset_inputs: assert (pin_oe_o == '0 && pin_o == '0);
  end

  a_r1_dir_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_DIR) |=> (pin_oe_o == $past(wdata_i)));
  a_r2_pin_from_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_PORT) |=> (pin_o == ($past(wdata_i) & pin_oe_o)));
endmodule

// File: tb/pio_port_tb.sv
module pio_port_tb;
  localparam int W = 8;
  logic         clk = 0;
  logic         rst_ni = 0;
  logic [1:0]   addr = 0;
  logic         wr_en = 0;
  logic [W-1:0] wdata = 0, rdata, pin_in = 0, pin_out, pin_oe;
  logic         strobe = 0, flag;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  pio_port u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wr_en_i(wr_en),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pin_in), .pin_o(pin_out),
    .pin_oe_o(pin_oe), .strobe_i(strobe), .flag_o(flag));

  task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic set_pins(input logic [W-1:0] p);
    @(negedge clk); pin_in = p;
    repeat (3) @(negedge clk);
  endtask

  task automatic set_strobe(input logic v);
    @(negedge clk); strobe = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(pin_oe, 8'h00, "R10 oe"); chk(pin_out, 8'h00, "R10 pin");
    rst_ni = 1;
    rd(2'd1, v); chk(v, 8'h00, "R10 dir");
    rd(2'd2, v); chk(v, 8'h00, "R10 ctrl");
    rd(2'd3, v); chk(v, 8'h00, "R10 flag");

    // R11 control readback, R1 direction readback
    wr(2'd2, 8'hFF); rd(2'd2, v); chk(v, 8'h07, "R11");
    wr(2'd2, 8'h00);
    wr(2'd1, 8'hC3); rd(2'd1, v); chk(v, 8'hC3, "R1 readback");

    // R3 output write while pins are inputs
    wr(2'd1, 8'h00); wr(2'd0, 8'h96);
    chk(pin_out, 8'h00, "R3 undriven"); chk(pin_oe, 8'h00, "R3 oe");
    wr(2'd1, 8'hFF); chk(pin_out, 8'h96, "R3 appears");

    // sweep of every direction value: R1 R2 R4 R5
    for (int d = 0; d < 256; d++) begin
      logic [W-1:0] dv, ov, pv;
      dv = d[7:0]; ov = dv ^ 8'hA5; pv = ~dv ^ 8'h3C;
      wr(2'd1, dv); wr(2'd0, ov); set_pins(pv);
      chk(pin_oe, dv, "R1 oe");
      chk(pin_out, ov & dv, "R2 pin");
      rd(2'd0, v); chk(v, pv, "R4 live");
      wr(2'd2, 8'h04);
      rd(2'd0, v); chk(v, (ov & dv) | (pv & ~dv), "R5 mix");
      wr(2'd2, 8'h00);
    end

    // flavour A latching, rising edge: R7 R9 R6
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h03);
    rd(2'd0, v); chk(v, 8'h00, "R7 before edge");
    set_pins(8'h11); set_strobe(1);
    chk(flag, 1'b1, "R6 rise sets");
    rd(2'd3, v); chk(v, 8'h01, "R6 flag reg");
    rd(2'd0, v); chk(v, 8'h11, "R7 snapshot");
    set_pins(8'h22); rd(2'd0, v); chk(v, 8'h11, "R7 held");
    set_strobe(0);
    chk(flag, 1'b1, "R6 fall inactive");
    set_pins(8'h33); set_strobe(1);
    rd(2'd0, v); chk(v, 8'h11, "R9 edge ignored");
    wr(2'd3, 8'h01);
    chk(flag, 1'b0, "R6 clear");
    rd(2'd0, v); chk(v, 8'h11, "R7 kept after clear");
    set_pins(8'h44); set_strobe(0); set_strobe(1);
    rd(2'd0, v); chk(v, 8'h44, "R7 new snapshot");

    // falling edge polarity
    wr(2'd3, 8'h01); wr(2'd2, 8'h01);
    chk(flag, 1'b0, "R6 no spurious");
    set_pins(8'h55); set_strobe(0);
    chk(flag, 1'b1, "R6 fall sets");
    rd(2'd0, v); chk(v, 8'h55, "R7 fall snapshot");

    // flavour B latching: R8
    wr(2'd2, 8'h07); wr(2'd3, 8'h01);
    wr(2'd1, 8'hF0); wr(2'd0, 8'hA0); set_pins(8'h05);
    set_strobe(1);
    rd(2'd0, v); chk(v, 8'hA5, "R8 captured mix");
    wr(2'd0, 8'h50); set_pins(8'h0A);
    rd(2'd0, v); chk(v, 8'hA5, "R8 held");
    wr(2'd3, 8'h01);
    rd(2'd0, v); chk(v, 8'h5A, "R8 live after clear");

    // set and clear in the same cycle: R6
    set_strobe(0);
    wr(2'd3, 8'h01);
    set_pins(8'h0C);
    @(negedge clk); strobe = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); addr = 2'd3; wdata = 8'h01; wr_en = 1;
    @(negedge clk); wr_en = 0;
    repeat (2) @(negedge clk);
    chk(flag, 1'b1, "R6 set wins");
    rd(2'd0, v); chk(v, 8'h5C, "R8 collision capture");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule